// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a small pipelined synchronous burst SRAM together with its control front end. Every control input, the address and the write data are taken on the rising clock edge. A new external address is accepted through one of two active-low address strobes. One belongs to the processor side and the other to the controller side. The two low address bits seed a 2-bit burst counter, which an active-low advance input then steps through the four words of an aligned group.

Writes go to a 36-bit word made of four 9-bit byte lanes. A global write stores all lanes. A qualified byte write stores only the lanes it selects. Reads are pipelined: the word fetched on an edge appears on the output bus after that edge. In place of tri-state pins, the model has separate input and output data buses and a drive-enable output. An output enable gates the drive, and that drive is held off for the first read after the device was deselected. A sleep input freezes the whole block and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted and after its release with no access, `drive_o` is 0 and `rdata_o` is all zeros.
- R2: A load cycle occurs when the controller strobe is low, or when the processor strobe is low together with `ce1_ni` low. A load cycle selects the device only if `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Otherwise the device is deselected, no access happens and `drive_o` is 0 in the following cycle.
- R3: A low processor strobe has no effect while `ce1_ni` is high. The cycle then behaves as a burst-continue cycle, so an active burst keeps reading.
- R4: When both strobes are low, the processor strobe wins. A cycle started by the processor strobe is always a read, and the write enables are ignored in it.
- R5: A selected load places `addr_i[1:0]` in the burst counter and accesses `addr_i`. In a non-load cycle of an active device, `adv_ni`=0 advances the counter by one and accesses the new address. `adv_ni`=1 accesses the same address again.
- R6: The burst counter wraps modulo 4 (3 to 0), and the upper address bits stay fixed during the burst.
- R7: In burst-continue cycles the three chip enables are ignored.
- R8: `gw_ni`=0 in an access cycle that is not started by the processor strobe writes all four lanes, whatever `bwe_ni` and `bw_ni` are. Lane i is `wdata_i[9i+8:9i]`. A write cycle drives no read data in the following cycle.
- R9: With `gw_ni`=1 and `bwe_ni`=0, lane i is written only when `bw_ni[i]`=0. With `gw_ni`=1 and `bwe_ni`=1, nothing is written and the cycle is a read.
- R10: The word read on a rising edge is present on `rdata_o` after that edge. `drive_o` is high only for a read, and only while `oe_ni` is low; `oe_ni`=1 clears `drive_o` at once.
- R11: The first read after a deselected state (reset or a deselecting load) keeps `drive_o` low for that cycle. The following reads drive normally.
- R12: While `sleep_i` is 1, there are no writes, the counter and the select state do not change, `rdata_o` holds and `drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write qualifier, active low |
| bw_ni | input | 4 | Per-lane byte selects, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |
| drive_o | output | 1 | Read data is being driven |

## Verification
The output-enable mask after a deselect is the hardest case to reach from the ports. It needs a deselecting load followed at once by a selected read load. The stimulus checks that the data register already holds the right word while `drive_o` stays low, and that the next burst beat drives. Sleep in the middle of a burst is applied with advance and global write both asserted. Releasing sleep with advance high then shows that neither the counter nor the array moved. The strobe priority is checked by pulling both strobes low during a global write and observing a read of the old word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              access_o,
  output logic              adsp_load_o,
  output logic              from_idle_o
);
  localparam int UP_W = ADDR_W - 2;

  logic            active_q;
  logic [UP_W-1:0] up_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_inc, cnt_use;
  logic            adsp_take, load, sel;

  // processor strobe counts only with ce1 asserted; it wins over the controller strobe
  assign adsp_take = !adsp_ni && !ce1_ni;
  assign load      = adsp_take || !adsc_ni;
  assign sel       = !ce1_ni && ce2_i && !ce3_ni;

  always_comb begin
    cnt_inc = cnt_q + 2'd1;
    cnt_use = adv_ni ? cnt_q : cnt_inc;
  end

  assign eff_addr_o  = load ? addr_i : {up_q, cnt_use};
  assign access_o    = load ? sel : active_q;
  assign adsp_load_o = adsp_take && sel;
  assign from_idle_o = !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      up_q     <= '0;
      cnt_q    <= '0;
    end else if (!hold_i) begin
      if (load) begin
        active_q <= sel;
        if (sel) begin
          up_q  <= addr_i[ADDR_W-1:2];
          cnt_q <= addr_i[1:0];
        end
      end else if (active_q) begin
        cnt_q <= cnt_use;
      end
    end
  end
endmodule

// File: rtl/sbs_write_dec.sv
module sbs_write_dec
  import sbs_pkg::*;
(
  input  logic       en_i,
  input  logic       gw_ni,
  input  logic       bwe_ni,
  input  lane_mask_t bw_ni,
  output lane_mask_t we_o
);
  always_comb begin
    if (!en_i)        we_o = '0;
    else if (!gw_ni)  we_o = '1;
    else if (!bwe_ni) we_o = ~bw_ni;
    else              we_o = '0;
  end
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  lane_mask_t        we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[l]) store[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = store[addr_i];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage
  import sbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              read_i,
  input  logic              from_idle_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else if (!hold_i) begin
      valid_q <= read_i;
      mask_q  <= read_i && from_idle_i;
      if (read_i) data_q <= word_i;
    end
  end

  assign rdata_o = data_q;
  // oe is asynchronous: not registered
  assign drive_o = valid_q && !mask_q && !oe_ni && !hold_i;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] eff_addr;
  logic              access, adsp_load, from_idle, wr_en, rd_en;
  lane_mask_t        lane_we;
  logic [DATA_W-1:0] mem_word;

  sbs_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .hold_i(sleep_i), .addr_i, .adsp_ni, .adsc_ni, .adv_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .eff_addr_o(eff_addr), .access_o(access),
    .adsp_load_o(adsp_load), .from_idle_o(from_idle)
  );

  // processor-strobe cycles are reads only
  assign wr_en = access && !adsp_load && !sleep_i;

  sbs_write_dec u_wdec (
    .en_i(wr_en), .gw_ni, .bwe_ni, .bw_ni, .we_o(lane_we)
  );

  assign rd_en = access && !sleep_i && (lane_we == '0);

  sbs_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(lane_we), .addr_i(eff_addr), .wdata_i, .rdata_o(mem_word)
  );

  sbs_out_stage u_out (
    .clk_i, .rst_ni, .hold_i(sleep_i), .read_i(rd_en), .from_idle_i(from_idle),
    .word_i(mem_word), .oe_ni, .rdata_o, .drive_o
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        adsp_ni,
  input logic        adsc_ni,
  input logic        ce1_ni,
  input logic        ce2_i,
  input logic        ce3_ni,
  input logic        gw_ni,
  input logic        bwe_ni,
  input logic        sleep_i,
  input logic [35:0] rdata_o,
  input logic        drive_o
);
  a_r2_desel_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && !ce2_i && !sleep_i) |=> !drive_o);

  a_r8_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_ni && adsp_ni && !sleep_i) |=> !drive_o);

  a_r11_first_read_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && !ce2_i && !sleep_i) ##1
    (!adsc_ni && !ce1_ni && ce2_i && !ce3_ni && gw_ni && bwe_ni && !sleep_i)
    |=> !drive_o);

  a_r12_sleep_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(rdata_o));
endmodule

bind sync_burst_sram sbs_checker i_sbs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .adsp_ni(adsp_ni), .adsc_ni(adsc_ni),
  .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni), .gw_ni(gw_ni),
  .bwe_ni(bwe_ni), .sleep_i(sleep_i), .rdata_o(rdata_o), .drive_o(drive_o)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr_i;
  logic          adsp_ni, adsc_ni, adv_ni, ce1_ni, ce2_i, ce3_ni;
  logic          gw_ni, bwe_ni, oe_ni, sleep_i;
  logic [3:0]    bw_ni;
  logic [35:0]   wdata_i, rdata_o;
  logic          drive_o;

  int total = 0;
  int bad   = 0;
  logic [35:0] exp_mem [64];

  always #4 clk_i = ~clk_i;

  sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
    .clk_i, .rst_ni, .addr_i, .adsp_ni, .adsc_ni, .adv_ni, .ce1_ni, .ce2_i,
    .ce3_ni, .gw_ni, .bwe_ni, .bw_ni, .oe_ni, .sleep_i, .wdata_i, .rdata_o, .drive_o
  );

  task automatic chk(string req, logic [35:0] act, logic [35:0] want);
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, want);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    adsp_ni = 1; adsc_ni = 1; adv_ni = 1;
    ce1_ni = 0; ce2_i = 1; ce3_ni = 0;
    gw_ni = 1; bwe_ni = 1; bw_ni = 4'hF;
    oe_ni = 0; sleep_i = 0; wdata_i = '0; addr_i = '0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    idle();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 drive in reset", 36'(drive_o), 36'd0);
    chk("R1 data in reset", rdata_o, 36'd0);
    rst_ni = 1;
    tick();
    chk("R1 drive after reset", 36'(drive_o), 36'd0);
    chk("R1 data after reset", rdata_o, 36'd0);
  endtask

  // write 22,23,20,21 through one burst with chip enables off after the load
  task automatic t_burst_write();
    idle();
    adsc_ni = 0; addr_i = 6'd22; gw_ni = 0; wdata_i = 36'hA_5000_0000;
    tick();
    exp_mem[22] = 36'hA_5000_0000;
    adsc_ni = 1; ce1_ni = 1; ce2_i = 0; ce3_ni = 1; adv_ni = 0; // R7: ignored
    for (int k = 1; k < 4; k++) begin
      wdata_i = 36'hA_5000_0000 + 36'(k) * 36'h1_2345_6789;
      tick();
      exp_mem[20 + ((2 + k) % 4)] = wdata_i;
    end
    chk("R8 write cycle no drive", 36'(drive_o), 36'd0);
    idle();
  endtask

  task automatic t_read_mask();
    idle();
    adsc_ni = 0; ce2_i = 0;
    tick();
    chk("R2 deselect no drive", 36'(drive_o), 36'd0);
    idle();
    adsc_ni = 0; addr_i = 6'd22;
    tick();
    chk("R11 first read masked", 36'(drive_o), 36'd0);
    chk("R10 data after one edge", rdata_o, exp_mem[22]);
    idle();
    adv_ni = 0;
    tick();
    chk("R11 second read drives", 36'(drive_o), 36'd1);
    chk("R5 R7 advance to 23", rdata_o, exp_mem[23]);
    tick();
    chk("R6 wrap to 20", rdata_o, exp_mem[20]);
    tick();
    chk("R5 advance to 21", rdata_o, exp_mem[21]);
    adv_ni = 1;
    oe_ni = 1; #1;
    chk("R10 oe high no drive", 36'(drive_o), 36'd0);
    oe_ni = 0; #1;
    chk("R10 oe low drives", 36'(drive_o), 36'd1);
  endtask

  task automatic t_byte_write();
    logic [35:0] w, m;
    idle();
    w = 36'h1_2345_6789;
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    adsc_ni = 0; addr_i = 6'd22; bwe_ni = 0; bw_ni = 4'b1010; wdata_i = w;
    tick();
    exp_mem[22] = (exp_mem[22] & ~m) | (w & m);
    idle();
    bw_ni = 4'b0000; wdata_i = 36'hF_FFFF_FFFF; // bwe high: no write
    tick();
    chk("R9 byte write lanes 0,2 drive", 36'(drive_o), 36'd1);
    chk("R9 byte write lanes 0,2", rdata_o, exp_mem[22]);
    idle();
    adv_ni = 0; gw_ni = 0; bwe_ni = 1; bw_ni = 4'hF; wdata_i = 36'h9_8765_4321;
    tick();
    exp_mem[23] = 36'h9_8765_4321;
    idle();
    tick();
    chk("R8 global write all lanes", rdata_o, exp_mem[23]);
  endtask

  task automatic t_priority();
    idle();
    adsp_ni = 0; adsc_ni = 0; addr_i = 6'd20; gw_ni = 0; wdata_i = 36'h0_DEAD_BEEF;
    tick();
    chk("R4 processor strobe read drives", 36'(drive_o), 36'd1);
    chk("R4 processor strobe read no write", rdata_o, exp_mem[20]);
  endtask

  task automatic t_adsp_ignored();
    idle();
    adsp_ni = 0; ce1_ni = 1; addr_i = 6'd9;
    tick();
    chk("R3 strobe ignored, burst drives", 36'(drive_o), 36'd1);
    chk("R3 strobe ignored, same word", rdata_o, exp_mem[20]);
  endtask

  task automatic t_deselect();
    idle();
    adsc_ni = 0; ce1_ni = 1;
    tick();
    chk("R2 controller strobe ce1 high deselects", 36'(drive_o), 36'd0);
    idle();
    adv_ni = 0;
    tick();
    chk("R2 stays deselected", 36'(drive_o), 36'd0);
  endtask

  task automatic t_sleep();
    idle();
    adsc_ni = 0; addr_i = 6'd20;
    tick();
    idle();
    adv_ni = 0;
    tick();
    chk("R5 burst before sleep", rdata_o, exp_mem[21]);
    sleep_i = 1; gw_ni = 0; wdata_i = 36'h0_0BAD_0BAD;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R12 sleep no drive", 36'(drive_o), 36'd0);
      chk("R12 sleep holds data", rdata_o, exp_mem[21]);
    end
    idle();
    tick();
    chk("R12 counter and word unchanged", rdata_o, exp_mem[21]);
    chk("R12 drive resumes", 36'(drive_o), 36'd1);
    adv_ni = 0;
    tick();
    chk("R12 burst resumes", rdata_o, exp_mem[22]);
    idle();
  endtask

  initial begin
    t_reset();
    t_burst_write();
    t_read_mask();
    t_byte_write();
    t_priority();
    t_adsp_ignored();
    t_deselect();
    t_sleep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule